// File: doc/BRIEF.md
# I2C Bypass Write Command Engine

This block is a small I2C master that pushes one register write into a power-management device. Software first loads a timing word that sets the SCL high and low durations, then writes a command word holding a 7-bit target address, an 8-bit register index, an 8-bit value and a go bit. The engine then runs the whole frame by itself: START, the address byte with the write direction bit, the register byte, the data byte, and STOP. It checks for an acknowledge after every byte.

When the frame ends, the go bit clears by itself. Software polls that bit to learn that the write is done. A byte that is not acknowledged cuts the frame short with a STOP and leaves a sticky error flag behind. The two bus lines are open-drain. Each one is modelled as an active-high pull-low enable plus a sampled input.

Top module: `pmic_wr_engine`

## Requirements
- R1: Command word fields: target address in bits [6:0], register index in [15:8], data value in [23:16], go bit in [24]. The word reads back with every other bit as zero. A write with bit 24 set starts a frame. A write with bit 24 clear only loads the fields.
- R2: A frame is START, then the byte {address, 0}, then the register byte, then the data byte, then STOP. Each byte goes out MSB first. SDA is released during the ninth SCL pulse of each byte so the target can acknowledge.
- R3: Timing word: SCL-high count in bits [7:0], SCL-low count in bits [15:8]. Every SCL low period lasts the low count plus 7 clock cycles. Every SCL high period inside a frame lasts the high count plus 5 clock cycles.
- R4: Inside a frame, SDA changes only while SCL is low. START is SDA falling with SCL high. STOP is SDA rising with SCL high. Each START and each STOP is followed by one full high period before anything else changes.
- R5: The go bit reads 1 from the write that starts a frame until the STOP completes. It then clears by itself, and the other command fields keep their values.
- R6: If a byte is not acknowledged (SDA high at the end of its ninth SCL pulse), no further byte is sent. The engine produces a STOP, clears the go bit and raises the error flag.
- R7: The error flag is sticky and is cleared by a one-cycle clear strobe. If a NACK completion and a clear strobe fall in the same cycle, the flag ends up set.
- R8: Any write to the command word while the go bit reads 1 is ignored: the fields and the frame in progress are unchanged.
- R9: After reset both bus enables are released, the command word reads 0 and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word write data |
| cmd_word | output | 32 | Command word readback, go bit in bit 24 |
| time_wr | input | 1 | Write strobe for the timing word |
| time_wdata | input | 16 | Timing word: high count [7:0], low count [15:8] |
| err_clear | input | 1 | Strobe that clears the error flag |
| nack_err | output | 1 | Sticky NACK error flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_i | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line |

## Verification
Two things can land in the same cycle: a frame ending after a NACK, which sets the error flag, and a software clear strobe. The bench holds the clear strobe high for the whole of a frame whose address byte it refuses. It then reads the flag at the first cycle where the go bit reads 0. The flag must be 1 at that point, and a lone strobe afterwards must bring it back to 0. A second overlap is a command write that arrives while a frame is running. This is judged from the bytes seen on the bus and from the readback word.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

  // Offsets added to the programmed counts
  localparam int HIGH_OFS = 5;
  localparam int LOW_OFS  = 7;
  localparam int FRAME_W  = 24;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_HIGH,
    PH_STOP_LOW,
    PH_STOP_HIGH,
    PH_STOP_FREE
  } phase_e;

  // Number of clock cycles spent in a bus phase
  function automatic int phase_len(input logic is_low, input int cnt);
    return cnt + (is_low ? LOW_OFS : HIGH_OFS);
  endfunction

  // Bit presented on SDA for a given byte/bit slot (MSB first)
  function automatic logic frame_bit(input logic [FRAME_W-1:0] f,
                                     input logic [1:0] byte_i,
                                     input logic [3:0] bit_i);
    int pos;
    pos = FRAME_W - 1 - (int'(byte_i) * 8 + int'(bit_i));
    return f[pos];
  endfunction

endpackage

// File: rtl/pwe_phase_timer.sv
module pwe_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/pwe_cmd_regs.sv
module pwe_cmd_regs #(
  parameter int         CNT_W  = 8,
  parameter logic [7:0] RST_HI = 8'd10,
  parameter logic [7:0] RST_LO = 8'd20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic             time_wr,
  input  logic [15:0]      time_wdata,
  input  logic             err_clear,
  input  logic             done,
  input  logic             done_nack,
  output logic             cmd_valid,
  output logic [6:0]       tgt_addr,
  output logic [7:0]       reg_addr,
  output logic [7:0]       data_byte,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_cnt,
  output logic             nack_err
);
  localparam int GO_BIT = 24;

  // The command word only accepts writes when no frame is pending
  logic cmd_accept;
  assign cmd_accept = cmd_wr && !cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      tgt_addr  <= '0;
      reg_addr  <= '0;
      data_byte <= '0;
    end else if (cmd_accept) begin
      tgt_addr  <= cmd_wdata[6:0];
      reg_addr  <= cmd_wdata[15:8];
      data_byte <= cmd_wdata[23:16];
      cmd_valid <= cmd_wdata[GO_BIT];
    end else if (done) begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= CNT_W'(RST_HI);
      lo_cnt <= CNT_W'(RST_LO);
    end else if (time_wr) begin
      hi_cnt <= time_wdata[CNT_W-1:0];
      lo_cnt <= time_wdata[8 +: CNT_W];
    end
  end

  // Setting the flag wins over clearing it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         nack_err <= 1'b0;
    else if (done_nack) nack_err <= 1'b1;
    else if (err_clear) nack_err <= 1'b0;
  end

  assert_cmd_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> ($stable(tgt_addr) && $stable(reg_addr) && $stable(data_byte)));

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cmd_valid);

  assert_err_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_nack |=> nack_err);
endmodule

// File: rtl/pmic_wr_engine.sv
module pmic_wr_engine #(
  parameter int         CNT_W  = 8,
  parameter logic [7:0] RST_HI = 8'd10,
  parameter logic [7:0] RST_LO = 8'd20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_word,
  input  logic        time_wr,
  input  logic [15:0] time_wdata,
  input  logic        err_clear,
  output logic        nack_err,
  output logic        scl_oe,
  input  logic        scl_i,
  output logic        sda_oe,
  input  logic        sda_i
);
  import pwe_pkg::*;

  localparam int DUR_W    = CNT_W + 4;
  localparam int LAST_BIT = 8;
  localparam int N_BYTES  = 3;

  logic             cmd_valid;
  logic [6:0]       tgt_addr;
  logic [7:0]       reg_addr, data_byte;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic             tick;
  phase_e           phase, nxt_phase;
  logic [1:0]       byte_i;
  logic [3:0]       bit_i;
  logic             nack_seen;
  logic [FRAME_W-1:0] frame;

  // Named internal events
  logic start_go, ack_slot_end, nack_now, last_byte, done, done_nack, tmr_load;
  logic [DUR_W-1:0] tmr_val;
  logic unused_scl;

  assign unused_scl = scl_i;  // no clock stretching: SCL input unused

  pwe_cmd_regs #(.CNT_W(CNT_W), .RST_HI(RST_HI), .RST_LO(RST_LO)) i_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .time_wr(time_wr), .time_wdata(time_wdata), .err_clear(err_clear),
    .done(done), .done_nack(done_nack), .cmd_valid(cmd_valid),
    .tgt_addr(tgt_addr), .reg_addr(reg_addr), .data_byte(data_byte),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .nack_err(nack_err)
  );

  pwe_phase_timer #(.W(DUR_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .tick(tick)
  );

  assign cmd_word = {7'd0, cmd_valid, data_byte, reg_addr, 1'b0, tgt_addr};
  assign frame    = {tgt_addr, 1'b0, reg_addr, data_byte};

  assign start_go     = (phase == PH_IDLE) && cmd_valid;
  assign ack_slot_end = (phase == PH_HIGH) && (bit_i == 4'(LAST_BIT)) && tick;
  assign nack_now     = ack_slot_end && sda_i;
  assign last_byte    = (byte_i == 2'(N_BYTES - 1));
  assign done         = (phase == PH_STOP_FREE) && tick;
  assign done_nack    = done && nack_seen;

  always_comb begin
    nxt_phase = phase;
    case (phase)
      PH_IDLE:      nxt_phase = cmd_valid ? PH_START : PH_IDLE;
      PH_START:     nxt_phase = PH_LOW;
      PH_LOW:       nxt_phase = PH_HIGH;
      PH_HIGH:      nxt_phase = (ack_slot_end && (sda_i || last_byte)) ? PH_STOP_LOW : PH_LOW;
      PH_STOP_LOW:  nxt_phase = PH_STOP_HIGH;
      PH_STOP_HIGH: nxt_phase = PH_STOP_FREE;
      default:      nxt_phase = PH_IDLE;
    endcase
  end

  assign tmr_load = start_go || ((phase != PH_IDLE) && tick);
  assign tmr_val  = DUR_W'(phase_len((nxt_phase == PH_LOW) || (nxt_phase == PH_STOP_LOW),
                                     int'(nxt_phase == PH_LOW || nxt_phase == PH_STOP_LOW
                                          ? lo_cnt : hi_cnt)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      byte_i    <= '0;
      bit_i     <= '0;
      nack_seen <= 1'b0;
    end else if (start_go) begin
      phase     <= PH_START;
      byte_i    <= '0;
      bit_i     <= '0;
      nack_seen <= 1'b0;
    end else if ((phase != PH_IDLE) && tick) begin
      phase <= nxt_phase;
      if (phase == PH_HIGH) begin
        if (ack_slot_end) begin
          nack_seen <= nack_now;
          if (!nack_now && !last_byte) begin
            byte_i <= byte_i + 1'b1;
            bit_i  <= '0;
          end
        end else begin
          bit_i <= bit_i + 1'b1;
        end
      end
    end
  end

  // Open-drain drive: 1 pulls the line low
  always_comb begin
    scl_oe = (phase == PH_LOW) || (phase == PH_STOP_LOW);
    case (phase)
      PH_START, PH_STOP_LOW, PH_STOP_HIGH: sda_oe = 1'b1;
      PH_LOW, PH_HIGH:
        sda_oe = (bit_i == 4'(LAST_BIT)) ? 1'b0 : !frame_bit(frame, byte_i, bit_i);
      default: sda_oe = 1'b0;
    endcase
  end

  assert_phase_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(phase) != PH_IDLE) && (phase != $past(phase))) |-> $past(tick));

  assert_sda_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) &&
     (phase == PH_LOW || phase == PH_HIGH || phase == PH_STOP_LOW)) |-> scl_oe);

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase == PH_IDLE));
endmodule

// File: tb/test_pmic_wr_engine.sv
module test_pmic_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, time_wr = 1'b0, err_clear = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [15:0] time_wdata = '0;
  logic [31:0] cmd_word;
  logic nack_err, scl_oe, sda_oe;
  logic slv_pull = 1'b0;
  logic scl_line, sda_line;

  int checks = 0, fails = 0;
  bit finished = 0;
  int nack_at = NONE;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_pull);

  always #(CLK_PERIOD/2) clk = !clk;

  pmic_wr_engine i_pmic_wr_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_word(cmd_word), .time_wr(time_wr), .time_wdata(time_wdata),
    .err_clear(err_clear), .nack_err(nack_err), .scl_oe(scl_oe),
    .scl_i(scl_line), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  // Bus monitor and target model
  int starts = 0, stops = 0, nbytes = 0, bitcnt = 0, run = 0;
  int lo_min, lo_max, hi_min, hi_max;
  bit in_frame = 0, seen_low = 0, prev_scl = 1, prev_sda = 1;
  logic [7:0] sh = '0;
  logic [7:0] got [3];

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_scl = 1; prev_sda = 1; in_frame = 0; slv_pull = 0; run = 0;
    end else begin
      if (scl_line && prev_scl && prev_sda && !sda_line) begin
        starts++; in_frame = 1; seen_low = 0; bitcnt = 0; nbytes = 0;
        lo_min = 1 << 20; lo_max = 0; hi_min = 1 << 20; hi_max = 0;
      end
      if (scl_line && prev_scl && !prev_sda && sda_line && in_frame) begin
        stops++; in_frame = 0;
      end
      if (scl_line != prev_scl) begin
        if (in_frame && !prev_scl) begin
          if (run < lo_min) lo_min = run;
          if (run > lo_max) lo_max = run;
          if (bitcnt < 8) sh = {sh[6:0], sda_line};
          bitcnt++;
        end
        if (in_frame && prev_scl) begin
          if (seen_low) begin
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
          end
          seen_low = 1;
          if (bitcnt == 8) begin
            if (nbytes < 3) got[nbytes] = sh;
            slv_pull = (nbytes != nack_at);
            nbytes++;
          end else if (bitcnt == 9) begin
            slv_pull = 0; bitcnt = 0;
          end
        end
        run = 1;
      end else begin
        run++;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wdata = w; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic write_time(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); time_wdata = {lo, hi}; time_wr = 1;
    @(negedge clk); time_wr = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (cmd_word[24] && g < 40000) begin @(negedge clk); g++; end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] a, input logic [7:0] r,
                                     input logic [7:0] d, input logic go);
    return {7'd0, go, d, r, 1'b0, a};
  endfunction

  // R9: reset state
  task automatic t_reset();
    chk("R9 cmd_word", cmd_word, 0);
    chk("R9 err", {31'd0, nack_err}, 0);
    chk("R9 scl_oe", {31'd0, scl_oe}, 0);
    chk("R9 sda_oe", {31'd0, sda_oe}, 0);
  endtask

  // R1/R2/R3/R4/R5/R6: one full frame with the given timing and NACK position
  task automatic t_xfer(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                        input logic [7:0] hi, input logic [7:0] lo, input int nk);
    int s0, p0, nexp;
    nack_at = nk;
    write_time(hi, lo);
    s0 = starts; p0 = stops;
    write_cmd(mk(a, r, d, 1'b1));
    chk("R1 readback with go", cmd_word, mk(a, r, d, 1'b1));
    wait_idle();
    repeat (3) @(negedge clk);
    nexp = (nk == NONE) ? 3 : nk + 1;
    chk("R4 one START", starts - s0, 1);
    chk("R6 one STOP", stops - p0, 1);
    chk("R2 byte count", nbytes, nexp);
    chk("R2 address byte", {24'd0, got[0]}, {24'd0, a, 1'b0});
    if (nexp > 1) chk("R2 register byte", {24'd0, got[1]}, {24'd0, r});
    if (nexp > 2) chk("R2 data byte", {24'd0, got[2]}, {24'd0, d});
    chk("R3 low min", lo_min, int'(lo) + 7);
    chk("R3 low max", lo_max, int'(lo) + 7);
    chk("R3 high min", hi_min, int'(hi) + 5);
    chk("R3 high max", hi_max, int'(hi) + 5);
    chk("R5 go cleared, fields kept", cmd_word, mk(a, r, d, 1'b0));
    chk("R6 error flag", {31'd0, nack_err}, (nk == NONE) ? 0 : 1);
    chk("R4 bus released", {30'd0, scl_oe, sda_oe}, 0);
    nack_at = NONE;
  endtask

  // R7: plain clear
  task automatic t_clear();
    @(negedge clk); err_clear = 1;
    @(negedge clk); err_clear = 0;
    chk("R7 clear strobe", {31'd0, nack_err}, 0);
  endtask

  // R1: load without go bit does not start
  task automatic t_load_only();
    int s0 = starts;
    write_cmd(mk(7'h12, 8'h34, 8'h56, 1'b0));
    chk("R1 load only readback", cmd_word, mk(7'h12, 8'h34, 8'h56, 1'b0));
    repeat (200) @(negedge clk);
    chk("R1 no frame without go", starts - s0, 0);
    chk("R1 SCL idle", {31'd0, scl_oe}, 0);
  endtask

  // R8: write during a frame is ignored
  task automatic t_busy_write();
    write_time(8'd6, 8'd9);
    write_cmd(mk(7'h2A, 8'h5C, 8'hE1, 1'b1));
    repeat (150) @(negedge clk);
    write_cmd(mk(7'h55, 8'hAA, 8'h0F, 1'b1));
    chk("R8 readback unchanged", cmd_word, mk(7'h2A, 8'h5C, 8'hE1, 1'b1));
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8 addr on bus", {24'd0, got[0]}, {24'd0, 7'h2A, 1'b0});
    chk("R8 reg on bus", {24'd0, got[1]}, 32'h5C);
    chk("R8 data on bus", {24'd0, got[2]}, 32'hE1);
  endtask

  // R7: NACK completion and clear strobe in the same cycle
  task automatic t_collide();
    nack_at = 0;
    write_time(8'd4, 8'd6);
    @(negedge clk); err_clear = 1;
    write_cmd(mk(7'h31, 8'h01, 8'h02, 1'b1));
    wait_idle();
    chk("R7 set wins over clear", {31'd0, nack_err}, 1);
    err_clear = 0;
    @(negedge clk);
    chk("R7 flag held after overlap", {31'd0, nack_err}, 1);
    nack_at = NONE;
    t_clear();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_xfer(7'h48, 8'h3C, 8'hA5, 8'd10, 8'd20, NONE);
    t_xfer(7'h7F, 8'h00, 8'hFF, 8'd0, 8'd0, NONE);
    t_xfer(7'h01, 8'h81, 8'h7E, 8'd25, 8'd40, NONE);
    t_load_only();
    t_xfer(7'h60, 8'h10, 8'h20, 8'd5, 8'd8, 0);
    t_clear();
    t_xfer(7'h33, 8'hC3, 8'h99, 8'd5, 8'd8, 2);
    t_clear();
    t_busy_write();
    t_collide();
    summary();
  end
endmodule